// File: doc/BRIEF.md
# Display Identification Fetch and Checksum Unit

This block walks a display sink through the steps needed to pull its identification data and prove that data intact. It does not drive any physical bus. Instead it issues byte-level read and write requests on an abstract request/response port, and an external transport (an I2C or auxiliary-channel engine) carries them out. A start pulse begins the walk. The unit first fetches the extension-count byte. It then reads the base 128-byte block and, when that count is nonzero, the following 128-byte block. Each block is summed modulo 256 and must total zero.

Once every block has passed, the unit reads a compliance test-request byte from the sink's native register space. If the identification-read test bit is set, it answers with two writes: first the checksum byte of the last block it read, then a fixed response code. The walk ends with a one-cycle `done` pulse. Any transport error or bad sum ends it with a one-cycle `error` pulse, and no further requests are issued. The captured checksum byte stays visible on `checksum`.

Requests use a valid/ready handshake that carries the following fields:
- direction
- address space: I2C device or native sink register
- device address
- offset
- length
- write data

Responses come back one byte per beat with an error flag. A write is acknowledged by a single beat.

Top module: `edid_fetch`

## Requirements
- R1: After synchronous reset, `req_valid`, `done` and `error` are low and `checksum` is 0.
- R2: The first request after `start` is an I2C read (`req_write`=0, `req_native`=0) of device 0x50, offset 126, length 1. It returns the extension count.
- R3: The base block is requested as an I2C read of device 0x50, offset 0, length 128. Its 128 bytes must sum to 0 modulo 256.
- R4: When the extension count is nonzero, a second I2C read of device 0x50, offset 128, length 128 follows. That block gets its own zero-sum check.
- R5: A block whose byte sum is nonzero ends the walk with an `error` pulse. No further request is issued afterwards.
- R6: A response beat with `rsp_err`=1 ends the walk with an `error` pulse at any step. No further request is issued afterwards.
- R7: `checksum` holds the byte at offset 127 of the last block fully read.
- R8: After all blocks pass, the unit issues a native read of register 0x218, length 1. If bit 2 of the returned byte is 1, two writes follow: `checksum` to native register 0x261, then 0x04 to native register 0x260. `done` follows the second acknowledgement.
- R9: If bit 2 of the test-request byte is 0, `done` pulses with no write request.
- R10: `done` and `error` are single-cycle pulses and never high together.
- R11: A `start` pulse while a walk is in progress is ignored. The request sequence is unchanged.
- R12: Once `req_valid` is high, it and all request fields stay stable until `req_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch walk (idle only) |
| req_valid | output | 1 | Transport request valid |
| req_ready | input | 1 | Transport accepts request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_native | output | 1 | 1 = native sink register space, 0 = I2C device |
| req_dev | output | 7 | I2C device address (0 for native) |
| req_addr | output | 16 | Byte offset or register address |
| req_len | output | 8 | Byte count |
| req_wdata | output | 8 | Write data byte |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 8 | Response byte |
| rsp_err | input | 1 | Transfer error, ends the transfer |
| done | output | 1 | Walk finished cleanly (pulse) |
| error | output | 1 | Walk aborted (pulse) |
| checksum | output | 8 | Offset-127 byte of last block read |

## Verification
The bench builds the unit with its default parameters. These are a 128-byte block, device 0x50, extension offset 126, and sink registers 0x218, 0x261 and 0x260. With these values the full two-block walk, followed by both compliance writes, fits in a few hundred cycles, so every abort point can be reached in its own short run. These abort points are:
- an error on the extension byte
- an error in the middle of a block
- a corrupted first block
- a corrupted second block
- an error on a write acknowledgement

A transport model with a programmable ready delay exercises request holding.

// File: rtl/edid_fetch.sv
module edid_fetch #(
  parameter int          BLOCK_LEN  = 128,
  parameter int          ADDR_W     = 16,
  parameter int          LEN_W      = 8,
  parameter logic [6:0]  EDID_DEV   = 7'h50,
  parameter int          EXT_OFFSET = 126,
  parameter int          TREQ_ADDR  = 'h218,
  parameter int          TCSUM_ADDR = 'h261,
  parameter int          TRESP_ADDR = 'h260,
  parameter int          TREQ_BIT   = 2,
  parameter logic [7:0]  TRESP_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic              req_native,
  output logic [6:0]        req_dev,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  input  logic              rsp_err,
  output logic              done,
  output logic              error,
  output logic [7:0]        checksum
);
  localparam int CNT_W = $clog2(BLOCK_LEN);

  typedef enum logic [3:0] {
    S_IDLE, S_EXT_RQ, S_EXT_WT, S_BLK_RQ, S_BLK_WT,
    S_TRQ_RQ, S_TRQ_WT, S_WCS_RQ, S_WCS_WT, S_WRS_RQ, S_WRS_WT
  } state_t;

  state_t           state;
  logic             ext_more, blk;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sum, csum_q;
  logic             done_q, err_q;

  wire [7:0] sum_next = sum + rsp_data;
  wire       last_beat = (cnt == CNT_W'(BLOCK_LEN - 1));

  assign req_valid = (state == S_EXT_RQ) || (state == S_BLK_RQ) || (state == S_TRQ_RQ) ||
                     (state == S_WCS_RQ) || (state == S_WRS_RQ);
  assign done     = done_q;
  assign error    = err_q;
  assign checksum = csum_q;

  always_comb begin
    req_write  = 1'b0;
    req_native = 1'b0;
    req_dev    = EDID_DEV;
    req_addr   = '0;
    req_len    = LEN_W'(1);
    req_wdata  = '0;
    case (state)
      S_EXT_RQ: req_addr = ADDR_W'(EXT_OFFSET);
      S_BLK_RQ: begin
        req_addr = blk ? ADDR_W'(BLOCK_LEN) : '0;
        req_len  = LEN_W'(BLOCK_LEN);
      end
      S_TRQ_RQ: begin
        req_native = 1'b1;
        req_dev    = '0;
        req_addr   = ADDR_W'(TREQ_ADDR);
      end
      S_WCS_RQ: begin
        req_write  = 1'b1;
        req_native = 1'b1;
        req_dev    = '0;
        req_addr   = ADDR_W'(TCSUM_ADDR);
        req_wdata  = csum_q;
      end
      S_WRS_RQ: begin
        req_write  = 1'b1;
        req_native = 1'b1;
        req_dev    = '0;
        req_addr   = ADDR_W'(TRESP_ADDR);
        req_wdata  = TRESP_CODE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ext_more <= 1'b0;
      blk      <= 1'b0;
      cnt      <= '0;
      sum      <= '0;
      csum_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) state <= S_EXT_RQ;
        S_EXT_RQ: if (req_ready) state <= S_EXT_WT;
        S_EXT_WT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            ext_more <= (rsp_data != 8'd0);
            blk      <= 1'b0;
            state    <= S_BLK_RQ;
          end
        end
        S_BLK_RQ: if (req_ready) begin
          cnt   <= '0;
          sum   <= '0;
          state <= S_BLK_WT;
        end
        S_BLK_WT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            sum <= sum_next;
            cnt <= cnt + 1'b1;
            if (last_beat) begin
              csum_q <= rsp_data;
              if (sum_next != 8'd0) begin
                err_q <= 1'b1;
                state <= S_IDLE;
              end else if (!blk && ext_more) begin
                blk   <= 1'b1;
                state <= S_BLK_RQ;
              end else begin
                state <= S_TRQ_RQ;
              end
            end
          end
        end
        S_TRQ_RQ: if (req_ready) state <= S_TRQ_WT;
        S_TRQ_WT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (rsp_data[TREQ_BIT]) begin
            state <= S_WCS_RQ;
          end else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_WCS_RQ: if (req_ready) state <= S_WCS_WT;
        S_WCS_WT: if (rsp_valid) begin
          err_q <= rsp_err;
          state <= rsp_err ? S_IDLE : S_WRS_RQ;
        end
        S_WRS_RQ: if (req_ready) state <= S_WRS_WT;
        S_WRS_WT: if (rsp_valid) begin
          err_q  <= rsp_err;
          done_q <= !rsp_err;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    error |-> !req_valid);
  assert_err_stops_R6: assert property (@(posedge clk) disable iff (rst)
    error && !start |=> !req_valid);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) &&
                                $stable(req_write) && $stable(req_native) && $stable(req_wdata));
  assert_write_native_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write |-> req_native);
  assert_block_len_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_native && req_addr != ADDR_W'(EXT_OFFSET) |-> req_len == LEN_W'(BLOCK_LEN));
endmodule

// File: tb/edid_fetch_test.sv
module edid_fetch_test;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic req_valid, req_ready = 1'b0, req_write, req_native;
  logic [6:0] req_dev;
  logic [15:0] req_addr;
  logic [7:0] req_len, req_wdata;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_data = 8'd0;
  logic done, error;
  logic [7:0] checksum;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  edid_fetch uut (
    .clk(clk), .rst(rst), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_native(req_native), .req_dev(req_dev), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .done(done), .error(error), .checksum(checksum)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [40:0] enc(input bit wr, input bit nat, input logic [6:0] dev,
                                      input int addr, input int len, input logic [7:0] wd);
    return {wr, nat, nat ? 7'd0 : dev, 16'(addr), 8'(len), wr ? wd : 8'd0};
  endfunction

  function automatic logic [7:0] blk_byte(input int b, input int i, input bit corrupt);
    int s = 0;
    if (i < 127) return 8'(i * 7 + b * 13 + 1 + ((corrupt && i == 5) ? 1 : 0));
    for (int k = 0; k < 127; k++) s += i * 0 + k * 7 + b * 13 + 1;
    return 8'(-s);
  endfunction

  task automatic run(input string tag, input int ext_val, input int corrupt_blk,
                     input int err_req, input int err_beat, input logic [7:0] treq,
                     input int delay, input bit busy_start);
    logic [40:0] exp_q[$], got_q[$], snap;
    int exp_out = 0, got_out = 0, idx = 0, nblk, beats = 0, bidx = 0, cur = -1, waitc;
    logic [7:0] exp_cs = 8'd0, got_cs;
    logic [40:0] curq;
    bit hold = 0;
    // expected sequence from the requirements
    exp_q.push_back(enc(0, 0, 7'h50, 126, 1, 0));
    if (err_req == 0) exp_out = 2;
    idx = 1;
    nblk = (ext_val != 0) ? 2 : 1;
    for (int b = 0; b < nblk && exp_out == 0; b++) begin
      exp_q.push_back(enc(0, 0, 7'h50, b * 128, 128, 0));
      if (err_req == idx) exp_out = 2;
      else begin
        exp_cs = blk_byte(b, 127, 0);
        if (corrupt_blk == b) exp_out = 2;
      end
      idx++;
    end
    if (exp_out == 0) begin
      exp_q.push_back(enc(0, 1, 0, 'h218, 1, 0));
      if (err_req == idx) exp_out = 2;
      else if (treq[2]) begin
        idx++;
        exp_q.push_back(enc(1, 1, 0, 'h261, 1, exp_cs));
        if (err_req == idx) exp_out = 2;
        else begin
          idx++;
          exp_q.push_back(enc(1, 1, 0, 'h260, 1, 8'h04));
          exp_out = (err_req == idx) ? 2 : 1;
        end
      end else exp_out = 1;
    end
    waitc = delay;
    @(negedge clk); start = 1'b1;
    for (int it = 0; it < 5000; it++) begin
      @(negedge clk);
      start = (busy_start && it == 30);
      if (hold) check({tag, " R12 hold"}, {63'd0, req_valid} | ({23'd0, enc(req_write, req_native, req_dev, req_addr, req_len, req_wdata)} << 1),
                      {63'd0, 1'b1} | ({23'd0, snap} << 1));
      if (done || error) begin
        got_out = done ? 1 : 2;
        got_cs = checksum;
        if (done && error) check("R10 exclusive", 1, 0);
        break;
      end
      rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = 8'd0;
      if (beats > 0) begin
        rsp_valid = 1'b1;
        if (curq[40]) rsp_data = 8'd0;
        else if (curq[39]) rsp_data = treq;
        else if (curq[31:16] == 16'd126) rsp_data = 8'(ext_val);
        else rsp_data = blk_byte(int'(curq[31:16]) / 128, bidx, int'(curq[31:16]) / 128 == corrupt_blk);
        if (cur == err_req && bidx == err_beat) begin rsp_err = 1'b1; beats = 0; end
        else beats--;
        bidx++;
      end
      req_ready = 1'b0; hold = 0;
      if (req_valid) begin
        snap = enc(req_write, req_native, req_dev, req_addr, req_len, req_wdata);
        if (waitc > 0) begin waitc--; hold = 1; end
        else begin
          req_ready = 1'b1; got_q.push_back(snap); cur = got_q.size() - 1; curq = snap;
          beats = snap[40] ? 1 : int'(snap[15:8]); bidx = 0; waitc = delay;
        end
      end
    end
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; start = 1'b0;
    check({tag, " request count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check(k == 0 ? "R2 first request" : {tag, " request"}, got_q[k], exp_q[k]);
    check({tag, " outcome"}, got_out, exp_out);
    if (exp_out == 1) check("R7 checksum", got_cs, exp_cs);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (req_valid || done || error) begin check("R10 R5 R6 quiet after end", 1, 0); break; end
    end
    checks++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {req_valid, done, error, checksum}, 11'd0);
    run("R3 single block", 0, -1, -1, 0, 8'h00, 0, 0);
    run("R4 two blocks R8", 2, -1, -1, 0, 8'h04, 2, 0);
    run("R8 test writes", 0, -1, -1, 0, 8'h04, 1, 0);
    run("R5 bad base sum", 1, 0, -1, 0, 8'h04, 0, 0);
    run("R5 bad ext sum", 1, 1, -1, 0, 8'h04, 0, 0);
    run("R6 ext read err", 1, -1, 0, 0, 8'h04, 0, 0);
    run("R6 mid block err", 1, -1, 1, 40, 8'h04, 1, 0);
    run("R9 no test bit", 1, -1, -1, 0, 8'hFB, 0, 0);
    run("R11 busy start", 1, -1, -1, 0, 8'h04, 0, 1);
    run("R6 write ack err", 1, -1, 4, 0, 8'h04, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule